// File: doc/BRIEF.md
# Clock-Driven Identification Byte Streamer

This block provides the transmit-only, read-only side of a 128-byte identification memory that shares one open-drain data line with a bidirectional I2C slave. A host pulses a dedicated streaming clock while it holds the I2C clock line high. Every rising edge of that streaming clock places the next bit of the stored table on the shared data line. The table is walked byte by byte, starting at address 0 after reset.

Each byte takes nine streaming-clock periods. The first eight carry the data bits, most significant bit first. In the ninth the line is left released. After that slot the byte address moves on by one, and it returns to 0 after the last location.

The streaming clock and the I2C clock are both synchronised into the system clock, and their edges are found by comparing successive samples. When the I2C clock is seen low, or when the on-chip I2C engine claims the line through the mode input, the block lets go of the data line and rewinds its position to the start of a byte. The block reads the memory through a combinational read port and never writes it.

Top module: `vclkIdStreamer`

## Requirements
- R1: After reset, sdaOe is 0 and memAddr is 0.
- R2: With sclIn high and i2cMode low, the first eight vclkIn rising edges of a frame present bits 7 down to 0 of the byte at memAddr, one new bit after each edge.
- R3: The ninth vclkIn rising edge of a frame releases the data line (sdaOe = 0).
- R4: On the ninth rising edge memAddr increments by one. From 127 it goes to 0.
- R5: When sclIn is sampled low, sdaOe goes to 0 and the bit position is cleared. With sclIn high again, the next frame starts at bit 7 of the same memAddr.
- R6: While i2cMode is 1, sdaOe is 0 in the same cycle and vclkIn edges neither move memAddr nor drive the line. When i2cMode returns to 0, streaming restarts at bit 7 of the unchanged memAddr.
- R7: vclkIn rising edges while sclIn is low leave memAddr unchanged and sdaOe at 0.
- R8: sdaOe is the open-drain pull-down enable: sdaOe = 1 for a presented data bit of 0, and sdaOe = 0 for a data bit of 1 or a released slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vclkIn | input | 1 | Streaming clock from the host, asynchronous |
| sclIn | input | 1 | Shared I2C clock line level, asynchronous |
| i2cMode | input | 1 | High while the bidirectional I2C engine owns the data line |
| memData | input | 8 | Byte read from the memory at memAddr, same cycle |
| memAddr | output | 7 | Current byte address for the memory read port |
| sdaOe | output | 1 | Pull the shared data line low when 1 |

## Verification
If the bit position is wrong, a byte shows up on the line rotated, or stretched past nine slots. The first affected byte makes this visible within a few streaming-clock periods. If the address is wrong, the port shows a skipped or repeated byte at the ninth edge of a frame, or a failure to return to 0 after location 127. If the release logic is wrong, the line stays pulled low after the I2C clock drops or after the mode input rises. Such a fault is visible within a few system clocks and blocks the bus for the I2C engine, so every frame is compared bit by bit and each hand-over is checked right after it happens.

// File: rtl/vclkStreamPkg.sv
package vclkStreamPkg;
  // Control-to-datapath strobes; at most one is set in any cycle.
  typedef struct packed {
    logic loadByte;    // first slot: take a fresh byte, present its MSB
    logic shiftBit;    // middle slots: present the next bit
    logic releaseBit;  // last slot: let the line go, step the address
    logic clearOut;    // streaming not permitted: let the line go
  } streamStrobe_t;
endpackage

// File: rtl/vclkStreamSync.sv
module vclkStreamSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/vclkStreamCtrl.sv
module vclkStreamCtrl
  import vclkStreamPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vclkIn,
  input  logic          sclIn,
  input  logic          i2cMode,
  output streamStrobe_t strobe
);
  localparam int SLOT_LAST = DATA_W;
  localparam int CNT_W     = $clog2(DATA_W + 1);

  logic vclkSync, sclSync, vclkPrev, vclkRise, active;
  logic [CNT_W-1:0] bitIdx;

  vclkStreamSync #(.STAGES(SYNC_STAGES)) u_vclkSync (
    .clk(clk), .rstN(rstN), .din(vclkIn), .dout(vclkSync));
  vclkStreamSync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vclkPrev <= 1'b0;
    else       vclkPrev <= vclkSync;
  end

  assign vclkRise = vclkSync & ~vclkPrev;
  assign active   = sclSync & ~i2cMode;

  // Slot position inside the nine-slot frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              bitIdx <= '0;
    else if (!active)                       bitIdx <= '0;
    else if (vclkRise) begin
      if (bitIdx == CNT_W'(SLOT_LAST))      bitIdx <= '0;
      else                                  bitIdx <= bitIdx + 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clearOut   = ~active;
    strobe.loadByte   = active & vclkRise & (bitIdx == '0);
    strobe.releaseBit = active & vclkRise & (bitIdx == CNT_W'(SLOT_LAST));
    strobe.shiftBit   = active & vclkRise & (bitIdx != '0)
                        & (bitIdx != CNT_W'(SLOT_LAST));
  end

  // R2: the datapath never receives two conflicting commands
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R5: a frame never resumes mid-byte after streaming was interrupted
  a_r5_restart_at_msb: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearOut |=> !(strobe.shiftBit || strobe.releaseBit));
endmodule

// File: rtl/vclkStreamData.sv
module vclkStreamData
  import vclkStreamPkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  streamStrobe_t              strobe,
  input  logic                       holdOff,
  input  logic [DATA_W-1:0]          memData,
  output logic [$clog2(DEPTH)-1:0]   memAddr,
  output logic                       sdaOe
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] shiftReg;
  logic              outBit, outValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr     <= '0;
      shiftReg <= '0;
      outBit   <= 1'b1;
      outValid <= 1'b0;
    end else if (strobe.clearOut) begin
      outValid <= 1'b0;
    end else if (strobe.loadByte) begin
      outBit   <= memData[DATA_W-1];
      shiftReg <= {memData[DATA_W-2:0], 1'b0};
      outValid <= 1'b1;
    end else if (strobe.shiftBit) begin
      outBit   <= shiftReg[DATA_W-1];
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end else if (strobe.releaseBit) begin
      outValid <= 1'b0;
      addr     <= (addr == ADDR_W'(DEPTH - 1)) ? '0 : addr + 1'b1;
    end
  end

  assign memAddr = addr;
  assign sdaOe   = outValid & ~outBit & ~holdOff;

  // R2: a frame start always puts a data bit on the line
  a_r2_load_drives: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadByte |=> outValid);

  // R3: the don't-care slot leaves the line released
  a_r3_release_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.releaseBit |=> !sdaOe);

  // R4: the address moves only at the end of a frame
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (addr != $past(addr)) |-> $past(strobe.releaseBit));

  // R4: the last location is followed by location 0
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.releaseBit && addr == ADDR_W'(DEPTH - 1)) |=> (addr == '0));
endmodule

// File: rtl/vclkIdStreamer.sv
module vclkIdStreamer
  import vclkStreamPkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     vclkIn,
  input  logic                     sclIn,
  input  logic                     i2cMode,
  input  logic [DATA_W-1:0]        memData,
  output logic [$clog2(DEPTH)-1:0] memAddr,
  output logic                     sdaOe
);
  streamStrobe_t strobe;

  vclkStreamCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .vclkIn(vclkIn), .sclIn(sclIn),
    .i2cMode(i2cMode), .strobe(strobe));

  vclkStreamData #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .holdOff(i2cMode),
    .memData(memData), .memAddr(memAddr), .sdaOe(sdaOe));

  // R7: with the clock line low for a full sync delay, the address holds
  a_r7_addr_hold_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!sclIn && $past(!sclIn) && $past(!sclIn, 2)) |=> $stable(memAddr));
endmodule

// File: tb/vclkIdStreamer_bench.sv
module vclkIdStreamer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vclkIn = 1'b0;
  logic       sclIn = 1'b1;
  logic       i2cMode = 1'b0;
  logic [7:0] memData;
  logic [6:0] memAddr;
  logic       sdaOe;

  int checkCnt = 0;
  int failCnt  = 0;
  int expAddr  = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] romByte(input int a);
    return 8'((a * 29 + 165) ^ (a << 1));
  endfunction

  assign memData = romByte(int'(memAddr));

  vclkIdStreamer u_vclkIdStreamer (
    .clk(clk), .rstN(rstN), .vclkIn(vclkIn), .sclIn(sclIn),
    .i2cMode(i2cMode), .memData(memData), .memAddr(memAddr), .sdaOe(sdaOe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic vclkPulse();
    @(negedge clk) vclkIn = 1'b1;
    repeat (6) @(negedge clk);
    vclkIn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bitPulses(input int first, input int count);
    logic [7:0] b;
    b = romByte(expAddr);
    for (int i = first; i < first + count; i++) begin
      vclkPulse();
      check(sdaOe == !b[7-i], "R2/R8 bit", int'(sdaOe), int'(!b[7-i]));
    end
  endtask

  task automatic testFrame();
    bitPulses(0, 8);
    vclkPulse();
    check(sdaOe == 1'b0, "R3 release slot", int'(sdaOe), 0);
    expAddr = (expAddr + 1) % 128;
    check(int'(memAddr) == expAddr, "R4 addr step", int'(memAddr), expAddr);
  endtask

  task automatic testReset();
    check(sdaOe == 1'b0, "R1 sdaOe", int'(sdaOe), 0);
    check(memAddr == 7'd0, "R1 memAddr", int'(memAddr), 0);
  endtask

  task automatic testSclAbort();
    bitPulses(0, 3);
    @(negedge clk) sclIn = 1'b0;
    repeat (8) @(negedge clk);
    check(sdaOe == 1'b0, "R5 released on scl low", int'(sdaOe), 0);
    vclkPulse();
    vclkPulse();
    check(int'(memAddr) == expAddr, "R7 addr held", int'(memAddr), expAddr);
    check(sdaOe == 1'b0, "R7 line idle", int'(sdaOe), 0);
    sclIn = 1'b1;
    repeat (8) @(negedge clk);
    testFrame();  // R5: restart at bit 7 of the same byte
  endtask

  task automatic testModeHandover();
    bitPulses(0, 2);
    @(negedge clk) i2cMode = 1'b1;
    #1 check(sdaOe == 1'b0, "R6 immediate release", int'(sdaOe), 0);
    vclkPulse();
    vclkPulse();
    vclkPulse();
    check(int'(memAddr) == expAddr, "R6 addr held", int'(memAddr), expAddr);
    check(sdaOe == 1'b0, "R6 line idle", int'(sdaOe), 0);
    @(negedge clk) i2cMode = 1'b0;
    repeat (4) @(negedge clk);
    testFrame();  // R6: restart at bit 7 of the same byte
  endtask

  task automatic testWrap();
    while (expAddr != 127) testFrame();
    testFrame();
    check(memAddr == 7'd0, "R4 wrap to 0", int'(memAddr), 0);
    testFrame();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    testReset();
    testFrame();
    testFrame();
    testSclAbort();
    testModeHandover();
    testWrap();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    report();
  end
endmodule